// File: doc/BRIEF.md
# Dual-Window On-Chip RAM Decoder

This block holds a small on-chip RAM (4 KiB by default) and makes it visible at two independently placed address windows. One window belongs to the instruction side and one to the data side. Each window has its own base register and its own control register, and bit 31 of the control register turns the window on. Base addresses are set at 64 MiB granularity. The RAM is mapped at the start of that 64 MiB page, and the rest of the page is unmapped.

Software sets up the windows through a device-control register bus. This bus carries a register number, a request strobe with a write flag, and 32-bit data. Two access ports then present addresses: a data port that can read and write, and an instruction port that only reads. Each port gets a response one cycle after its request is accepted. The response carries a hit flag, and on a read hit it also carries the addressed RAM word. Both windows reach the same physical words, so a word written through one window can be read through the other.

Both ports use valid/ready. The data port is always ready. The instruction port drops ready in the one case where both ports would need the single RAM port in the same cycle. While ready is low, the instruction requester must hold valid and its address steady. Responses have no back-pressure, so a requester must take each response in the cycle it appears.

Top module: `dual_window_ram`

## Requirements
- R1: Register numbers are decoded as follows: 0x018 is the instruction-window base, 0x019 the instruction-window control, 0x01A the data-window base and 0x01B the data-window control. Writes to any other number are ignored, and reads of any other number return zero.
- R2: A base register keeps only bits 31:26 of a write. Bits 25:0 read back as zero.
- R3: A control register keeps only bits 31:30 of a write, and bits 29:0 read back as zero. Bit 31 enables the window. Bit 30 is stored and read back but does not affect decoding.
- R4: After reset, all four registers read zero, both windows are disabled, and every access on either port misses.
- R5: A register read strobe produces cfg_rvalid together with the register value in cfg_rdata on the next clock cycle, and only then.
- R6: A window hits when all three conditions hold: it is enabled, address bits 31:26 equal its base, and address bits 25:OFF are zero, where OFF = log2(RAM_WORDS)+2. The RAM word index is taken from address bits OFF-1:2. The data port hits if either enabled window matches. The instruction port hits only through the instruction window.
- R7: One cycle after a request is accepted, the port raises rsp_valid together with rsp_hit. A read hit returns the RAM word. A miss, or a write, returns rdata of zero. A write that misses leaves the RAM unchanged.
- R8: Both windows reach the same RAM words, so a word written by the data port is returned by an instruction read at the same word index through the instruction window.
- R9: When both windows are enabled with the same base, an access at that page is decoded once: it produces a single response and reads and writes a single word. If the instruction window is then disabled, the data port still hits.
- R10: d_ready is always 1. When both ports present hitting requests in the same cycle, the data port takes the RAM, i_ready is 0 for that cycle, and the held instruction request is accepted once the conflict is gone. If only one of the two requests hits, both requests are accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req | input | 1 | Register access strobe |
| cfg_we | input | 1 | Register access is a write when 1 |
| cfg_num | input | 10 | Register number |
| cfg_wdata | input | 32 | Register write data |
| cfg_rvalid | output | 1 | Register read data valid |
| cfg_rdata | output | 32 | Register read data |
| d_valid | input | 1 | Data request valid |
| d_ready | output | 1 | Data request accepted (always 1) |
| d_we | input | 1 | Data request is a write |
| d_addr | input | 32 | Data byte address |
| d_wdata | input | 32 | Data write word |
| d_rsp_valid | output | 1 | Data response valid |
| d_rsp_hit | output | 1 | Data response hit flag |
| d_rdata | output | 32 | Data read word |
| i_valid | input | 1 | Instruction request valid |
| i_ready | output | 1 | Instruction request accepted |
| i_addr | input | 32 | Instruction byte address |
| i_rsp_valid | output | 1 | Instruction response valid |
| i_rsp_hit | output | 1 | Instruction response hit flag |
| i_rdata | output | 32 | Instruction read word |

## Verification
The bench builds the block with RAM_WORDS = 16 and keeps the 32-bit address and the 6-bit base. With only 16 words, every word index is touched many times. This size also lets the bench sweep all 64 base placements of the data window, testing at each one a hit, a gap-bit miss and a neighbouring-page miss. At that small size the bench can also run the full alias, shared-base and port-conflict sequences, and it predicts every response from its own word model.

// File: rtl/dws_pkg.sv
package dws_pkg;
  localparam int CFG_NUM_W = 10;
  localparam logic [CFG_NUM_W-1:0] CFG_FIRST = 10'h018;
  localparam int NUM_WIN   = 2;
  localparam int WIN_INSTR = 0;
  localparam int WIN_DATA  = 1;
  localparam int CTRL_W    = 2;

  // window w owns two consecutive numbers: base, then control
  function automatic logic [CFG_NUM_W-1:0] win_reg_num(input int w, input logic is_ctrl);
    return CFG_FIRST + CFG_NUM_W'(2 * w + int'(is_ctrl));
  endfunction
endpackage

// File: rtl/dws_cfg_regs.sv
module dws_cfg_regs
  import dws_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BASE_W = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_req,
  input  logic                              cfg_we,
  input  logic [CFG_NUM_W-1:0]              cfg_num,
  input  logic [DATA_W-1:0]                 cfg_wdata,
  output logic                              cfg_rvalid,
  output logic [DATA_W-1:0]                 cfg_rdata,
  output logic [NUM_WIN-1:0][BASE_W-1:0]    win_base,
  output logic [NUM_WIN-1:0]                win_en
);
  localparam int LOW_B = DATA_W - BASE_W;
  localparam int LOW_C = DATA_W - CTRL_W;

  logic [NUM_WIN-1:0][BASE_W-1:0] base_q;
  logic [NUM_WIN-1:0][CTRL_W-1:0] ctrl_q;
  logic [NUM_WIN-1:0]             sel_base, sel_ctrl;
  logic [DATA_W-1:0]              rd_next;
  logic                           mapped;
  logic                           unused_wdata;

  assign unused_wdata = ^cfg_wdata[LOW_B-1:0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_sel
    assign sel_base[w] = (cfg_num == win_reg_num(w, 1'b0));
    assign sel_ctrl[w] = (cfg_num == win_reg_num(w, 1'b1));
    assign win_base[w] = base_q[w];
    assign win_en[w]   = ctrl_q[w][CTRL_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      ctrl_q <= '0;
    end else if (cfg_req && cfg_we) begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (sel_base[w]) base_q[w] <= cfg_wdata[DATA_W-1 -: BASE_W];
        if (sel_ctrl[w]) ctrl_q[w] <= cfg_wdata[DATA_W-1 -: CTRL_W];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    mapped  = 1'b0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (sel_base[w]) begin
        rd_next = {base_q[w], {LOW_B{1'b0}}};
        mapped  = 1'b1;
      end
      if (sel_ctrl[w]) begin
        rd_next = {ctrl_q[w], {LOW_C{1'b0}}};
        mapped  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_rvalid <= 1'b0;
      cfg_rdata  <= '0;
    end else begin
      cfg_rvalid <= cfg_req && !cfg_we;
      if (cfg_req && !cfg_we) cfg_rdata <= rd_next;
    end
  end

  // R5: read data arrives exactly one cycle after a read strobe
  p_rd_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_we) |=> cfg_rvalid);
  p_no_stray_rvalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_req && !cfg_we) |=> !cfg_rvalid);
  // R1: unmapped numbers read zero
  p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_we && !mapped) |=> (cfg_rdata == '0));
  // R2: low bits of any readback are never set
  p_base_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rvalid |-> (cfg_rdata[LOW_B-1:0] == '0));
endmodule

// File: rtl/dws_win_match.sv
module dws_win_match #(
  parameter int ADDR_W = 32,
  parameter int BASE_W = 6,
  parameter int OFF_W  = 12
) (
  input  logic                    en,
  input  logic [BASE_W-1:0]       base,
  input  logic [ADDR_W-OFF_W-1:0] page,
  output logic                    hit
);
  localparam int GAP_W = ADDR_W - OFF_W - BASE_W;

  logic base_eq, gap_clear;
  assign base_eq   = (page[ADDR_W-OFF_W-1 -: BASE_W] == base);
  assign gap_clear = (page[GAP_W-1:0] == '0);
  assign hit       = en && base_eq && gap_clear;
endmodule

// File: rtl/dws_ram.sv
module dws_ram #(
  parameter int WORDS  = 1024,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[idx] <= wdata;
      else    rdata    <= mem[idx];
    end
  end
endmodule

// File: rtl/dws_port_arb.sv
module dws_port_arb #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d_valid,
  input  logic              d_we,
  input  logic [IDX_W-1:0]  d_idx,
  input  logic [DATA_W-1:0] d_wdata,
  input  logic              d_hit,
  input  logic              i_valid,
  input  logic [IDX_W-1:0]  i_idx,
  input  logic              i_hit,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              d_ready,
  output logic              i_ready,
  output logic              ram_en,
  output logic              ram_we,
  output logic [IDX_W-1:0]  ram_idx,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              d_rsp_valid,
  output logic              d_rsp_hit,
  output logic [DATA_W-1:0] d_rdata,
  output logic              i_rsp_valid,
  output logic              i_rsp_hit,
  output logic [DATA_W-1:0] i_rdata
);
  logic d_go, i_go, d_rd_q, i_rd_q;

  assign d_ready   = 1'b1;
  assign d_go      = d_valid && d_hit;
  assign i_ready   = !(d_go && i_hit);
  assign i_go      = i_valid && i_ready && i_hit;
  assign ram_en    = d_go || i_go;
  assign ram_we    = d_go && d_we;
  assign ram_idx   = d_go ? d_idx : i_idx;
  assign ram_wdata = d_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_rsp_valid <= 1'b0;
      d_rsp_hit   <= 1'b0;
      d_rd_q      <= 1'b0;
      i_rsp_valid <= 1'b0;
      i_rsp_hit   <= 1'b0;
      i_rd_q      <= 1'b0;
    end else begin
      d_rsp_valid <= d_valid;
      d_rsp_hit   <= d_go;
      d_rd_q      <= d_go && !d_we;
      i_rsp_valid <= i_valid && i_ready;
      i_rsp_hit   <= i_go;
      i_rd_q      <= i_go;
    end
  end

  assign d_rdata = d_rd_q ? ram_rdata : '0;
  assign i_rdata = i_rd_q ? ram_rdata : '0;

  // R10: a double hit stalls the instruction port
  p_istall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && d_hit && i_valid && i_hit) |-> !i_ready);
  // R7: every data request is answered next cycle
  p_dresp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid |=> d_rsp_valid);
  // R7: a miss carries no data
  p_imiss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (i_rsp_valid && !i_rsp_hit) |-> (i_rdata == '0));
  p_dmiss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (d_rsp_valid && !d_rsp_hit) |-> (d_rdata == '0));
endmodule

// File: rtl/dual_window_ram.sv
module dual_window_ram
  import dws_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int BASE_W    = 6,
  parameter int RAM_WORDS = 1024
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_req,
  input  logic                 cfg_we,
  input  logic [CFG_NUM_W-1:0] cfg_num,
  input  logic [DATA_W-1:0]    cfg_wdata,
  output logic                 cfg_rvalid,
  output logic [DATA_W-1:0]    cfg_rdata,
  input  logic                 d_valid,
  output logic                 d_ready,
  input  logic                 d_we,
  input  logic [ADDR_W-1:0]    d_addr,
  input  logic [DATA_W-1:0]    d_wdata,
  output logic                 d_rsp_valid,
  output logic                 d_rsp_hit,
  output logic [DATA_W-1:0]    d_rdata,
  input  logic                 i_valid,
  output logic                 i_ready,
  input  logic [ADDR_W-1:0]    i_addr,
  output logic                 i_rsp_valid,
  output logic                 i_rsp_hit,
  output logic [DATA_W-1:0]    i_rdata
);
  localparam int IDX_W = $clog2(RAM_WORDS);
  localparam int OFF_W = IDX_W + 2;

  logic [NUM_WIN-1:0][BASE_W-1:0] win_base;
  logic [NUM_WIN-1:0]             win_en;
  logic [NUM_WIN-1:0]             d_hit_win;
  logic                           d_hit, i_hit;
  logic                           ram_en, ram_we;
  logic [IDX_W-1:0]               ram_idx;
  logic [DATA_W-1:0]              ram_wdata, ram_rdata;
  logic                           unused_lsb;

  assign unused_lsb = ^{d_addr[1:0], i_addr[1:0]};

  dws_cfg_regs #(.DATA_W(DATA_W), .BASE_W(BASE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we),
    .cfg_num(cfg_num), .cfg_wdata(cfg_wdata), .cfg_rvalid(cfg_rvalid),
    .cfg_rdata(cfg_rdata), .win_base(win_base), .win_en(win_en)
  );

  // data side sees every enabled window
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_dmatch
    dws_win_match #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .OFF_W(OFF_W)) u_match (
      .en(win_en[w]), .base(win_base[w]),
      .page(d_addr[ADDR_W-1:OFF_W]), .hit(d_hit_win[w])
    );
  end
  assign d_hit = |d_hit_win;

  // instruction side sees only its own window
  dws_win_match #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .OFF_W(OFF_W)) u_imatch (
    .en(win_en[WIN_INSTR]), .base(win_base[WIN_INSTR]),
    .page(i_addr[ADDR_W-1:OFF_W]), .hit(i_hit)
  );

  dws_port_arb #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .d_valid(d_valid), .d_we(d_we), .d_idx(d_addr[OFF_W-1:2]),
    .d_wdata(d_wdata), .d_hit(d_hit),
    .i_valid(i_valid), .i_idx(i_addr[OFF_W-1:2]), .i_hit(i_hit),
    .ram_rdata(ram_rdata), .d_ready(d_ready), .i_ready(i_ready),
    .ram_en(ram_en), .ram_we(ram_we), .ram_idx(ram_idx), .ram_wdata(ram_wdata),
    .d_rsp_valid(d_rsp_valid), .d_rsp_hit(d_rsp_hit), .d_rdata(d_rdata),
    .i_rsp_valid(i_rsp_valid), .i_rsp_hit(i_rsp_hit), .i_rdata(i_rdata)
  );

  dws_ram #(.WORDS(RAM_WORDS), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .en(ram_en), .we(ram_we), .idx(ram_idx),
    .wdata(ram_wdata), .rdata(ram_rdata)
  );

  // R4: with no window enabled nothing can hit
  p_closed_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_en == '0) |-> (!d_hit && !i_hit));
  // R7: the RAM is written only by a hitting data write
  p_ram_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (d_valid && d_we && d_hit));
  // R9: windows sharing a base decode identically
  p_same_base_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_en == '1) && (win_base[0] == win_base[1])) |-> (d_hit_win[0] == d_hit_win[1]));
endmodule

// File: tb/dual_window_ram_test.sv
module dual_window_ram_test;
  localparam int WORDS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_req = 1'b0, cfg_we = 1'b0;
  logic [9:0]  cfg_num = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_rvalid;
  logic [31:0] cfg_rdata;
  logic        d_valid = 1'b0, d_we = 1'b0;
  logic [31:0] d_addr = '0, d_wdata = '0;
  logic        d_ready, d_rsp_valid, d_rsp_hit;
  logic [31:0] d_rdata;
  logic        i_valid = 1'b0;
  logic [31:0] i_addr = '0;
  logic        i_ready, i_rsp_valid, i_rsp_hit;
  logic [31:0] i_rdata;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [31:0] model [WORDS];

  always #2 clk = ~clk;

  dual_window_ram #(.RAM_WORDS(WORDS)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we),
    .cfg_num(cfg_num), .cfg_wdata(cfg_wdata), .cfg_rvalid(cfg_rvalid),
    .cfg_rdata(cfg_rdata), .d_valid(d_valid), .d_ready(d_ready), .d_we(d_we),
    .d_addr(d_addr), .d_wdata(d_wdata), .d_rsp_valid(d_rsp_valid),
    .d_rsp_hit(d_rsp_hit), .d_rdata(d_rdata), .i_valid(i_valid),
    .i_ready(i_ready), .i_addr(i_addr), .i_rsp_valid(i_rsp_valid),
    .i_rsp_hit(i_rsp_hit), .i_rdata(i_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [9:0] num, input logic [31:0] val);
    @(negedge clk);
    cfg_req = 1'b1; cfg_we = 1'b1; cfg_num = num; cfg_wdata = val;
    @(negedge clk);
    cfg_req = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [9:0] num, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_req = 1'b1; cfg_we = 1'b0; cfg_num = num;
    @(negedge clk);
    cfg_req = 1'b0;
    chk({tag, " R5 rvalid"}, {31'b0, cfg_rvalid}, 32'd1);
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic d_acc(input logic [31:0] addr, input logic we, input logic [31:0] wd,
                       input logic exp_hit, input logic [31:0] exp_rd, input string tag);
    @(negedge clk);
    d_valid = 1'b1; d_we = we; d_addr = addr; d_wdata = wd;
    @(negedge clk);
    d_valid = 1'b0; d_we = 1'b0;
    chk({tag, " R7 d_rsp_valid"}, {31'b0, d_rsp_valid}, 32'd1);
    chk({tag, " hit"}, {31'b0, d_rsp_hit}, {31'b0, exp_hit});
    chk({tag, " rdata"}, d_rdata, exp_rd);
  endtask

  task automatic i_acc(input logic [31:0] addr, input logic exp_hit,
                       input logic [31:0] exp_rd, input string tag);
    @(negedge clk);
    i_valid = 1'b1; i_addr = addr;
    @(negedge clk);
    i_valid = 1'b0;
    chk({tag, " R7 i_rsp_valid"}, {31'b0, i_rsp_valid}, 32'd1);
    chk({tag, " hit"}, {31'b0, i_rsp_hit}, {31'b0, exp_hit});
    chk({tag, " rdata"}, i_rdata, exp_rd);
  endtask

  function automatic logic [31:0] wa(input logic [5:0] base, input int idx);
    return {base, 26'b0} | (32'(idx) << 2);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R4: reset state
    for (int k = 0; k < 4; k++) cfg_rd(10'h018 + 10'(k), 32'h0, "R4 reset reg");
    d_acc(32'h0, 1'b0, 32'h0, 1'b0, 32'h0, "R4 data miss after reset");
    i_acc(32'h0, 1'b0, 32'h0, "R4 instr miss after reset");

    // R1 R2 R3: register numbers and masks
    for (int p = 0; p < 3; p++) begin
      logic [31:0] pat;
      pat = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'hA5A5_A5A5 : 32'h5A5A_5A5A;
      for (int k = 0; k < 4; k++) begin
        cfg_wr(10'h018 + 10'(k), pat ^ 32'(k));
        cfg_rd(10'h018 + 10'(k),
               (k % 2 == 0) ? ((pat ^ 32'(k)) & 32'hFC00_0000) : ((pat ^ 32'(k)) & 32'hC000_0000),
               (k % 2 == 0) ? "R2 base mask" : "R3 ctrl mask");
      end
    end
    cfg_wr(10'h017, 32'hFFFF_FFFF);
    cfg_wr(10'h01C, 32'hFFFF_FFFF);
    cfg_wr(10'h118, 32'hFFFF_FFFF);
    cfg_rd(10'h017, 32'h0, "R1 unmapped 0x017");
    cfg_rd(10'h01C, 32'h0, "R1 unmapped 0x01C");
    cfg_rd(10'h118, 32'h0, "R1 unmapped 0x118");
    cfg_rd(10'h018, 32'h5800_0000, "R1 base kept after unmapped writes");
    cfg_rd(10'h01B, 32'h4000_0000, "R1 ctrl kept after unmapped writes");
    for (int k = 0; k < 4; k++) cfg_wr(10'h018 + 10'(k), 32'h0);

    // R6: sweep every data-window base
    for (int b = 0; b < 64; b++) begin
      int idx;
      logic [31:0] v;
      idx = b % WORDS;
      v = 32'h1000_0000 + 32'(b) * 32'h0001_0203;
      cfg_wr(10'h01A, {6'(b), 26'h2AB_CDEF});
      cfg_wr(10'h01B, 32'h8000_0000);
      d_acc(wa(6'(b), idx), 1'b1, v, 1'b1, 32'h0, "R7 write hit returns zero");
      model[idx] = v;
      d_acc(wa(6'(b), idx), 1'b0, 32'h0, 1'b1, v, "R6 base sweep hit");
      d_acc(wa(6'(b), idx) | ((b % 2 == 0) ? 32'h40 : 32'h0200_0000), 1'b0, 32'h0,
            1'b0, 32'h0, "R6 gap bit miss");
      d_acc(wa(6'(b + 1), idx), 1'b0, 32'h0, 1'b0, 32'h0, "R6 other page miss");
      i_acc(wa(6'(b), idx), 1'b0, 32'h0, "R6 instr ignores data window");
    end

    // R3: bit 30 alone does not enable
    cfg_wr(10'h01B, 32'h4000_0000);
    d_acc(wa(6'd63, 15), 1'b0, 32'h0, 1'b0, 32'h0, "R3 bit30 no enable");

    // R8: alias through separate windows
    cfg_wr(10'h018, 32'h0C00_0000);
    cfg_wr(10'h019, 32'hC000_0000);
    cfg_wr(10'h01A, 32'h3000_0000);
    cfg_wr(10'h01B, 32'h8000_0000);
    for (int k = 0; k < WORDS; k++) begin
      model[k] = 32'hA000_0000 | (32'(k) * 32'h0011_0101);
      d_acc(wa(6'h0C, k), 1'b1, model[k], 1'b1, 32'h0, "R7 write");
    end
    for (int k = 0; k < WORDS; k++) begin
      i_acc(wa(6'h03, k), 1'b1, model[k], "R8 instr reads data write");
      d_acc(wa(6'h03, k), 1'b0, 32'h0, 1'b1, model[k], "R6 data via instr window");
    end

    // R7: missing write leaves RAM unchanged
    d_acc(wa(6'h0C, 3) | 32'h40, 1'b1, 32'hDEAD_BEEF, 1'b0, 32'h0, "R7 write miss");
    d_acc(wa(6'h0C, 3), 1'b0, 32'h0, 1'b1, model[3], "R7 RAM unchanged");

    // R10: both hit -> instruction stalls one cycle
    @(negedge clk);
    d_valid = 1'b1; d_we = 1'b0; d_addr = wa(6'h0C, 1);
    i_valid = 1'b1; i_addr = wa(6'h03, 2);
    #1;
    chk("R10 d_ready", {31'b0, d_ready}, 32'd1);
    chk("R10 stall on double hit", {31'b0, i_ready}, 32'd0);
    @(negedge clk);
    chk("R10 data served first", d_rdata, model[1]);
    chk("R10 no instr rsp while stalled", {31'b0, i_rsp_valid}, 32'd0);
    d_valid = 1'b0;
    #1;
    chk("R10 ready after conflict", {31'b0, i_ready}, 32'd1);
    @(negedge clk);
    i_valid = 1'b0;
    chk("R10 instr rsp valid", {31'b0, i_rsp_valid}, 32'd1);
    chk("R10 instr data", i_rdata, model[2]);

    // R10: data miss plus instr hit both accepted
    @(negedge clk);
    d_valid = 1'b1; d_addr = wa(6'h0F, 0);
    i_valid = 1'b1; i_addr = wa(6'h03, 4);
    #1;
    chk("R10 no stall on single hit", {31'b0, i_ready}, 32'd1);
    @(negedge clk);
    d_valid = 1'b0; i_valid = 1'b0;
    chk("R10 data miss rsp", {30'b0, d_rsp_valid, d_rsp_hit}, 32'd2);
    chk("R10 instr hit rsp", {30'b0, i_rsp_valid, i_rsp_hit}, 32'd3);
    chk("R10 instr hit data", i_rdata, model[4]);

    // R9: shared base
    cfg_wr(10'h018, 32'h0800_0000);
    cfg_wr(10'h01A, 32'h0800_0000);
    for (int k = 0; k < WORDS; k++) begin
      model[k] = 32'h5000_0000 + 32'(k * 7);
      d_acc(wa(6'h02, k), 1'b1, model[k], 1'b1, 32'h0, "R9 shared write");
    end
    for (int k = 0; k < WORDS; k++) begin
      d_acc(wa(6'h02, k), 1'b0, 32'h0, 1'b1, model[k], "R9 shared data read");
      i_acc(wa(6'h02, k), 1'b1, model[k], "R9 shared instr read");
    end
    cfg_wr(10'h019, 32'h0);
    d_acc(wa(6'h02, 5), 1'b0, 32'h0, 1'b1, model[5], "R9 data survives instr disable");
    i_acc(wa(6'h02, 5), 1'b0, 32'h0, "R9 instr closed");

    // R4: reset again
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cfg_rd(10'h01A, 32'h0, "R4 base after reset");
    cfg_rd(10'h01B, 32'h0, "R4 ctrl after reset");
    d_acc(wa(6'h02, 5), 1'b0, 32'h0, 1'b0, 32'h0, "R4 miss after second reset");

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule